// File: doc/BRIEF.md
# Tag-RAM ECC Scrub and Retry Controller

This block sits between a set-associative cache lookup and the RAM holding its tags. Every tag entry is stored as a codeword that covers a valid bit and the tag. The code corrects any single flipped bit and detects any two flipped bits. A lookup names a set and a compare tag. The block reads all ways of that set at once, decodes every way in parallel and answers hit or miss together with the matching way. When no way holds an error, the answer appears in the cycle after the request is accepted. The next request can be accepted in that same cycle.

When a way holds an error, the block stalls the lookup and scrubs the entry. A correctable entry is written back in corrected form. An uncorrectable entry is overwritten with an encoded invalid entry. Each scrub raises a one-cycle error report that carries the set, the way and a flag marking the error as correctable or not. The block then reads the set again and retries the lookup. An error that shows up again on the way just corrected is taken to be a hard fault: that way is invalidated and excluded for the rest of the lookup, so a stuck bit cannot trap the block in a loop.

The tag width is a parameter and must be 30, 31 or 32 bits. The number of sets and ways are also parameters.

Top module: `tag_ecc_scrubber`

## Requirements
- R1: After synchronous reset, `req_ready` is 1 and `rsp_valid`, `err_valid` and `ram_wr_en` are 0.
- R2: If no way of the addressed set holds an error, `rsp_valid` is 1 exactly one cycle after acceptance. `rsp_hit` is 1 when some way is valid and its tag equals the compare tag, and `rsp_way` gives the lowest such way. A new request is accepted in the same cycle, so back-to-back lookups answer on consecutive cycles.
- R3: On a single-bit error, `req_ready` is low and no response is given while the corrected codeword is written to the faulty way. The set is then reread and the lookup retried, and the response comes 4 cycles after acceptance.
- R4: Each scrub write comes with an `err_valid` pulse one cycle long that carries the set and the way. `err_uncorr` is 0 for a corrected error and 1 otherwise.
- R5: On an uncorrectable error (two flipped bits), the way is rewritten with the encoded entry {valid=0, tag=0} and `err_uncorr` is 1. After the retry, that way never hits.
- R6: If the retry finds an error again on the way that was just corrected, the error is treated as uncorrectable. The way is invalidated and ignored for the rest of the lookup, and the lookup ends 7 cycles after acceptance.
- R7: When several ways hold errors, they are scrubbed one per retry, starting from the lowest-numbered way.
- R8: Codeword format. The data word is {valid, tag}, with the valid bit as the MSB. Codeword bit p-1 holds Hamming position p, for p = 1..TAG_W+7. Positions that are powers of two hold check bits: position 2^c is the even parity of all data positions whose index has bit c set. Data bits fill the other positions in order from data LSB upward. The top bit is the even parity of all the lower codeword bits.
- R9: On acceptance, `ram_rd_en` is 1 in the same cycle with `ram_rd_set` equal to `req_set`. Read data for all ways is expected one cycle later, with way w at bits [w*CW +: CW].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Lookup request |
| req_ready | output | 1 | Request accepted when both valid and ready |
| req_set | input | SET_W | Set index of the lookup |
| req_tag | input | TAG_W | Tag to compare |
| rsp_valid | output | 1 | Lookup result present |
| rsp_hit | output | 1 | A valid way matched |
| rsp_way | output | WAY_W | Lowest matching way |
| ram_rd_en | output | 1 | Tag RAM read strobe |
| ram_rd_set | output | SET_W | Set to read |
| ram_rd_data | input | WAYS*CW | Codewords of all ways, one cycle after the read |
| ram_wr_en | output | 1 | Scrub write strobe |
| ram_wr_set | output | SET_W | Set to write |
| ram_wr_way | output | WAY_W | Way to write |
| ram_wr_data | output | CW | Codeword to write |
| err_valid | output | 1 | Error report pulse |
| err_set | output | SET_W | Set of the faulty entry |
| err_way | output | WAY_W | Way of the faulty entry |
| err_uncorr | output | 1 | 1 when the entry was invalidated |

## Verification
A decoder that gets the syndrome wrong shows up on the RAM write port in the scrub cycle, two cycles after acceptance: the codeword written back is not the clean encoding of the original entry. A wrong way-priority or persistence state shows up as a wrong `err_way`, a wrong `err_uncorr` or a wrong number of report pulses. Each of these also moves the response off its expected cycle of 1, 4 or 7. A corrupted kill mask shows up as a hit on an invalidated way, or as a lookup that never ends, which the watchdog catches.

// File: rtl/tag_ecc_pkg.sv
package tag_ecc_pkg;

    // Hamming check bits, enough for up to 57 data bits
    localparam int CHK_BITS = 6;

    typedef enum logic [1:0] {
        ST_RUN    = 2'd0,
        ST_FIX    = 2'd1,
        ST_REREAD = 2'd2
    } scrub_state_e;

    typedef enum logic [1:0] {
        ECC_CLEAN  = 2'd0,
        ECC_CORR   = 2'd1,
        ECC_UNCORR = 2'd2
    } ecc_status_e;

    function automatic logic is_pow2(input int p);
        return (p > 0) && ((p & (p - 1)) == 0);
    endfunction

endpackage

// File: rtl/tag_secded_enc.sv
module tag_secded_enc import tag_ecc_pkg::*; #(
    parameter int DW = 33,
    localparam int N  = DW + CHK_BITS,
    localparam int CW = N + 1
) (
    input  logic [DW-1:0] data_i,
    output logic [CW-1:0] cw_o
);

    logic [N:1] pos;

    always_comb begin
        int unsigned k;
        logic        par;
        k   = 0;
        pos = '0;
        // place data bits in non-power-of-two positions
        for (int p = 1; p <= N; p++) begin
            if (!is_pow2(p)) begin
                pos[p] = data_i[k];
                k++;
            end
        end
        // each check bit covers positions that have its bit set
        for (int c = 0; c < CHK_BITS; c++) begin
            par = 1'b0;
            for (int p = 1; p <= N; p++) begin
                if (((p >> c) & 1) == 1 && !is_pow2(p)) par ^= pos[p];
            end
            pos[1 << c] = par;
        end
        cw_o = {^pos, pos};
    end

endmodule

// File: rtl/tag_secded_dec.sv
module tag_secded_dec import tag_ecc_pkg::*; #(
    parameter int DW = 33,
    localparam int N  = DW + CHK_BITS,
    localparam int CW = N + 1
) (
    input  logic [CW-1:0] cw_i,
    output ecc_status_e   status_o,
    output logic [CW-1:0] fixed_o,
    output logic [DW-1:0] data_o
);

    logic [CHK_BITS-1:0] syn;
    logic                odd;

    always_comb begin
        syn = '0;
        for (int p = 1; p <= N; p++) begin
            if (cw_i[p-1]) syn ^= CHK_BITS'(p);
        end
        odd = ^cw_i;
    end

    always_comb begin
        fixed_o  = cw_i;
        status_o = ECC_CLEAN;
        if (!odd) begin
            // even overall parity: clean or double error
            status_o = (syn == '0) ? ECC_CLEAN : ECC_UNCORR;
        end else if (syn == '0) begin
            // only the overall parity bit flipped
            fixed_o[CW-1] = ~cw_i[CW-1];
            status_o      = ECC_CORR;
        end else if (int'(syn) <= N) begin
            fixed_o[int'(syn)-1] = ~cw_i[int'(syn)-1];
            status_o             = ECC_CORR;
        end else begin
            // syndrome points outside the word: multi-bit error
            status_o = ECC_UNCORR;
        end
    end

    always_comb begin
        int unsigned k;
        k      = 0;
        data_o = '0;
        for (int p = 1; p <= N; p++) begin
            if (!is_pow2(p)) begin
                data_o[k] = fixed_o[p-1];
                k++;
            end
        end
    end

endmodule

// File: rtl/tag_way_probe.sv
module tag_way_probe import tag_ecc_pkg::*; #(
    parameter int TAG_W = 32,
    localparam int DW = TAG_W + 1,
    localparam int CW = DW + CHK_BITS + 1
) (
    input  logic [CW-1:0]    cw_i,
    input  logic [TAG_W-1:0] cmp_tag_i,
    input  logic             killed_i,
    output logic             match_o,
    output logic             err_o,
    output ecc_status_e      status_o,
    output logic [CW-1:0]    fixed_o
);

    logic [DW-1:0] word;

    tag_secded_dec #(.DW(DW)) i_dec (
        .cw_i     (cw_i),
        .status_o (status_o),
        .fixed_o  (fixed_o),
        .data_o   (word)
    );

    // a killed way neither hits nor raises an error
    always_comb begin
        err_o   = !killed_i && (status_o != ECC_CLEAN);
        match_o = !killed_i && (status_o == ECC_CLEAN) &&
                  word[DW-1] && (word[TAG_W-1:0] == cmp_tag_i);
    end

endmodule

// File: rtl/tag_ecc_scrubber.sv
module tag_ecc_scrubber import tag_ecc_pkg::*; #(
    parameter int TAG_W = 32,
    parameter int SET_W = 6,
    parameter int WAYS  = 4,
    localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1,
    localparam int DW    = TAG_W + 1,
    localparam int CW    = DW + CHK_BITS + 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 req_valid,
    output logic                 req_ready,
    input  logic [SET_W-1:0]     req_set,
    input  logic [TAG_W-1:0]     req_tag,
    output logic                 rsp_valid,
    output logic                 rsp_hit,
    output logic [WAY_W-1:0]     rsp_way,
    output logic                 ram_rd_en,
    output logic [SET_W-1:0]     ram_rd_set,
    input  logic [WAYS*CW-1:0]   ram_rd_data,
    output logic                 ram_wr_en,
    output logic [SET_W-1:0]     ram_wr_set,
    output logic [WAY_W-1:0]     ram_wr_way,
    output logic [CW-1:0]        ram_wr_data,
    output logic                 err_valid,
    output logic [SET_W-1:0]     err_set,
    output logic [WAY_W-1:0]     err_way,
    output logic                 err_uncorr
);

    scrub_state_e     state_q;
    logic             s1_valid_q, s1_retry_q;
    logic [SET_W-1:0] s1_set_q;
    logic [TAG_W-1:0] s1_tag_q;
    logic [WAYS-1:0]  kill_q;
    logic [WAY_W-1:0] last_way_q;
    logic             last_corr_q;
    logic [WAY_W-1:0] fix_way_q;
    logic             fix_uncorr_q;
    logic [CW-1:0]    fix_cw_q;

    logic [WAYS-1:0]  way_match, way_err;
    ecc_status_e      way_status [WAYS];
    logic [CW-1:0]    way_fixed  [WAYS];
    logic [CW-1:0]    inv_cw;

    // encoded empty entry used to invalidate a way
    tag_secded_enc #(.DW(DW)) i_inv_enc (
        .data_i ('0),
        .cw_o   (inv_cw)
    );

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        tag_way_probe #(.TAG_W(TAG_W)) i_probe (
            .cw_i      (ram_rd_data[w*CW +: CW]),
            .cmp_tag_i (s1_tag_q),
            .killed_i  (kill_q[w]),
            .match_o   (way_match[w]),
            .err_o     (way_err[w]),
            .status_o  (way_status[w]),
            .fixed_o   (way_fixed[w])
        );
    end

    // lowest-numbered faulty way and lowest matching way
    logic             found_err, found_hit;
    logic [WAY_W-1:0] sel_err_way, sel_hit_way;
    ecc_status_e      sel_status;
    logic [CW-1:0]    sel_fixed;

    always_comb begin
        found_err   = 1'b0;
        found_hit   = 1'b0;
        sel_err_way = '0;
        sel_hit_way = '0;
        sel_status  = ECC_CLEAN;
        sel_fixed   = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (way_err[w]) begin
                found_err   = 1'b1;
                sel_err_way = WAY_W'(w);
                sel_status  = way_status[w];
                sel_fixed   = way_fixed[w];
            end
            if (way_match[w]) begin
                found_hit   = 1'b1;
                sel_hit_way = WAY_W'(w);
            end
        end
    end

    logic look_now, blocked, persistent, sel_uncorr, accept;

    always_comb begin
        look_now   = (state_q == ST_RUN) && s1_valid_q;
        blocked    = look_now && found_err;
        persistent = s1_retry_q && last_corr_q && (sel_err_way == last_way_q);
        sel_uncorr = (sel_status == ECC_UNCORR) || persistent;
        req_ready  = (state_q == ST_RUN) && !blocked;
        accept     = req_valid && req_ready;
    end

    // lookup response
    always_comb begin
        rsp_valid = look_now && !found_err;
        rsp_hit   = rsp_valid && found_hit;
        rsp_way   = rsp_hit ? sel_hit_way : '0;
    end

    // tag RAM ports
    always_comb begin
        ram_rd_en   = accept || (state_q == ST_REREAD);
        ram_rd_set  = (state_q == ST_REREAD) ? s1_set_q : req_set;
        ram_wr_en   = (state_q == ST_FIX);
        ram_wr_set  = s1_set_q;
        ram_wr_way  = fix_way_q;
        ram_wr_data = fix_cw_q;
    end

    // error report
    always_comb begin
        err_valid  = (state_q == ST_FIX);
        err_set    = s1_set_q;
        err_way    = fix_way_q;
        err_uncorr = fix_uncorr_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q      <= ST_RUN;
            s1_valid_q   <= 1'b0;
            s1_retry_q   <= 1'b0;
            s1_set_q     <= '0;
            s1_tag_q     <= '0;
            kill_q       <= '0;
            last_way_q   <= '0;
            last_corr_q  <= 1'b0;
            fix_way_q    <= '0;
            fix_uncorr_q <= 1'b0;
            fix_cw_q     <= '0;
        end else begin
            unique case (state_q)
                ST_RUN: begin
                    if (blocked) begin
                        state_q      <= ST_FIX;
                        fix_way_q    <= sel_err_way;
                        fix_uncorr_q <= sel_uncorr;
                        fix_cw_q     <= sel_uncorr ? inv_cw : sel_fixed;
                    end else begin
                        s1_valid_q <= accept;
                        if (accept) begin
                            s1_set_q    <= req_set;
                            s1_tag_q    <= req_tag;
                            s1_retry_q  <= 1'b0;
                            kill_q      <= '0;
                            last_corr_q <= 1'b0;
                        end
                    end
                end
                ST_FIX: begin
                    state_q     <= ST_REREAD;
                    last_way_q  <= fix_way_q;
                    last_corr_q <= !fix_uncorr_q;
                    if (fix_uncorr_q) kill_q[fix_way_q] <= 1'b1;
                end
                ST_REREAD: begin
                    state_q    <= ST_RUN;
                    s1_retry_q <= 1'b1;
                end
                default: state_q <= ST_RUN;
            endcase
        end
    end

    // R4
    err_single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        err_valid |=> !err_valid);

    // R3
    retry_follows_fix_chk: assert property (@(posedge clk) disable iff (rst)
        ram_wr_en |=> (ram_rd_en && ram_rd_set == $past(ram_wr_set)));

    // R2
    rsp_after_read_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> $past(ram_rd_en));

    // R3
    no_rsp_during_scrub_chk: assert property (@(posedge clk) disable iff (rst)
        ram_wr_en |-> (!rsp_valid && !req_ready));

    // R6
    kill_never_shrinks_chk: assert property (@(posedge clk) disable iff (rst)
        (s1_retry_q && !accept) |=> ($countones(kill_q) >= $countones($past(kill_q))));

endmodule

// File: tb/test_tag_ecc_scrubber.sv
module test_tag_ecc_scrubber;

    localparam int TAG_W = 32;
    localparam int SET_W = 4;
    localparam int WAYS  = 2;
    localparam int SETS  = 1 << SET_W;
    localparam int DW    = TAG_W + 1;
    localparam int N     = DW + 6;
    localparam int CW    = N + 1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;

    logic             req_valid = 1'b0;
    logic             req_ready;
    logic [SET_W-1:0] req_set = '0;
    logic [TAG_W-1:0] req_tag = '0;
    logic             rsp_valid, rsp_hit;
    logic [0:0]       rsp_way;
    logic             ram_rd_en;
    logic [SET_W-1:0] ram_rd_set;
    logic [WAYS*CW-1:0] ram_rd_data;
    logic             ram_wr_en;
    logic [SET_W-1:0] ram_wr_set;
    logic [0:0]       ram_wr_way;
    logic [CW-1:0]    ram_wr_data;
    logic             err_valid, err_uncorr;
    logic [SET_W-1:0] err_set;
    logic [0:0]       err_way;

    tag_ecc_scrubber #(.TAG_W(TAG_W), .SET_W(SET_W), .WAYS(WAYS)) i_tag_ecc_scrubber (
        .clk, .rst, .req_valid, .req_ready, .req_set, .req_tag,
        .rsp_valid, .rsp_hit, .rsp_way,
        .ram_rd_en, .ram_rd_set, .ram_rd_data,
        .ram_wr_en, .ram_wr_set, .ram_wr_way, .ram_wr_data,
        .err_valid, .err_set, .err_way, .err_uncorr
    );

    // tag RAM model; stuck masks model hard faults on the read path
    logic [CW-1:0] mem   [SETS][WAYS];
    logic [CW-1:0] stuck [SETS][WAYS];
    always @(posedge clk) begin
        if (ram_wr_en) mem[ram_wr_set][ram_wr_way] <= ram_wr_data;
        if (ram_rd_en)
            for (int w = 0; w < WAYS; w++)
                ram_rd_data[w*CW +: CW] <= mem[ram_rd_set][w] ^ stuck[ram_rd_set][w];
    end

    // R8 encoding, written from the requirement text
    function automatic logic [CW-1:0] enc(input logic valid, input logic [TAG_W-1:0] tag);
        logic [DW-1:0] d;
        logic [N:1]    h;
        int            k;
        d = {valid, tag};
        h = '0;
        k = 0;
        for (int p = 1; p <= N; p++)
            if ((p & (p - 1)) != 0) begin h[p] = d[k]; k++; end
        for (int c = 0; c < 6; c++)
            for (int p = 1; p <= N; p++)
                if ((p & (p - 1)) != 0 && ((p >> c) & 1) == 1) h[1 << c] ^= h[p];
        return {^h, h};
    endfunction

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;

    task automatic chk(input logic ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 20000);
            finish_run();
        end
    end

    function automatic logic [TAG_W-1:0] tag_a(input int s); return 32'hA500_0000 + s; endfunction
    function automatic logic [TAG_W-1:0] tag_b(input int s); return 32'h5A00_0000 + s; endfunction

    task automatic preload(input int s);
        mem[s][0]   = enc(1'b1, tag_a(s));
        mem[s][1]   = enc(1'b1, tag_b(s));
        stuck[s][0] = '0;
        stuck[s][1] = '0;
    endtask

    // results of the last lookup
    int          lat, n_err, first_way, last_uncorr;
    logic        got_hit;
    logic [0:0]  got_way;

    // called at a negedge with the block idle
    task automatic lookup(input logic [SET_W-1:0] s, input logic [TAG_W-1:0] t, input string req);
        req_valid = 1'b1;
        req_set   = s;
        req_tag   = t;
        #1;
        chk(ram_rd_en && ram_rd_set == s, "R9", {ram_rd_en, ram_rd_set}, {1'b1, s});
        @(posedge clk);
        @(negedge clk);
        req_valid   = 1'b0;
        lat         = 1;
        n_err       = 0;
        first_way   = -1;
        last_uncorr = 0;
        while (!rsp_valid && lat < 40) begin
            if (err_valid) begin
                if (n_err == 0) first_way = err_way;
                n_err++;
                last_uncorr = err_uncorr;
                chk(err_set == s, req, err_set, s);
            end
            @(negedge clk);
            lat++;
        end
        got_hit = rsp_hit;
        got_way = rsp_way;
    endtask

    typedef struct packed {
        logic [3:0]  set;
        logic [31:0] tag;
        logic [39:0] flip0;
        logic [39:0] flip1;
        logic        stuck;
        logic        hit;
        logic        way;
        logic [1:0]  errs;
        logic        first;
        logic        uncorr;
        logic [3:0]  lat;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        // clean hits and a miss: R2
        '{4'd1, 32'hA500_0001, 40'h0, 40'h0, 1'b0, 1'b1, 1'b0, 2'd0, 1'b0, 1'b0, 4'd1},
        '{4'd2, 32'h5A00_0002, 40'h0, 40'h0, 1'b0, 1'b1, 1'b1, 2'd0, 1'b0, 1'b0, 4'd1},
        '{4'd3, 32'h1234_5678, 40'h0, 40'h0, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 4'd1},
        // single data-bit error: R3 R4
        '{4'd4, 32'hA500_0004, 40'h20, 40'h0, 1'b0, 1'b1, 1'b0, 2'd1, 1'b0, 1'b0, 4'd4},
        // overall parity bit flipped: R3
        '{4'd5, 32'h5A00_0005, 40'h0, 40'h80_0000_0000, 1'b0, 1'b1, 1'b1, 2'd1, 1'b1, 1'b0, 4'd4},
        // double error invalidates the hitting way: R5
        '{4'd6, 32'hA500_0006, 40'h10_0008, 40'h0, 1'b0, 1'b0, 1'b0, 2'd1, 1'b0, 1'b1, 4'd4},
        // both ways faulty, way 0 first: R7
        '{4'd7, 32'h5A00_0007, 40'h2, 40'h400, 1'b0, 1'b1, 1'b1, 2'd2, 1'b0, 1'b0, 4'd7},
        // stuck bit on way 0: R6
        '{4'd8, 32'hA500_0008, 40'h1000, 40'h0, 1'b1, 1'b0, 1'b0, 2'd2, 1'b0, 1'b1, 4'd7},
        // double error on way 0, hit on way 1: R5
        '{4'd9, 32'h5A00_0009, 40'h3, 40'h0, 1'b0, 1'b1, 1'b1, 2'd1, 1'b0, 1'b1, 4'd4}
    };

    initial begin
        for (int s = 0; s < SETS; s++) preload(s);
        ram_rd_data = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1
        chk(req_ready == 1'b1, "R1", req_ready, 1);
        chk(rsp_valid == 1'b0, "R1", rsp_valid, 0);
        chk(err_valid == 1'b0, "R1", err_valid, 0);
        chk(ram_wr_en == 1'b0, "R1", ram_wr_en, 0);

        for (int i = 0; i < NV; i++) begin
            vec_t v;
            v = VECS[i];
            preload(v.set);
            if (v.stuck) stuck[v.set][0] = v.flip0;
            else mem[v.set][0] = mem[v.set][0] ^ v.flip0;
            mem[v.set][1] = mem[v.set][1] ^ v.flip1;
            lookup(v.set, v.tag, "R4");
            chk(lat == int'(v.lat), "R3 latency", lat, v.lat);
            chk(got_hit == v.hit, "R2 hit", got_hit, v.hit);
            if (v.hit) chk(got_way == v.way, "R2 way", got_way, v.way);
            chk(n_err == int'(v.errs), "R4 reports", n_err, v.errs);
            if (v.errs != 0) begin
                chk(first_way == int'(v.first), "R7 first way", first_way, v.first);
                chk(last_uncorr == int'(v.uncorr), "R6 uncorr flag", last_uncorr, v.uncorr);
            end
            stuck[v.set][0] = '0;
            @(negedge clk);
        end

        // R3: scrubbed entry holds the clean codeword again
        chk(mem[4][0] == enc(1'b1, tag_a(4)), "R3 writeback", mem[4][0], enc(1'b1, tag_a(4)));
        chk(mem[7][1] == enc(1'b1, tag_b(7)), "R7 writeback", mem[7][1], enc(1'b1, tag_b(7)));
        // R5: invalid entry written, later lookup clean miss
        chk(mem[6][0] == enc(1'b0, '0), "R5 invalidate", mem[6][0], enc(1'b0, '0));
        lookup(4'd6, tag_a(6), "R5");
        chk(!got_hit && lat == 1 && n_err == 0, "R5 later miss", {got_hit, lat[3:0]}, 5'h01);
        // R6: stuck-fault entry invalidated
        chk(mem[8][0] == enc(1'b0, '0), "R6 invalidate", mem[8][0], enc(1'b0, '0));

        // R2: back-to-back lookups answer on consecutive cycles
        preload(10);
        preload(11);
        req_valid = 1'b1;
        req_set   = 4'd10;
        req_tag   = tag_b(10);
        @(posedge clk);
        @(negedge clk);
        chk(req_ready == 1'b1, "R2 ready", req_ready, 1);
        req_set = 4'd11;
        req_tag = tag_a(11);
        chk(rsp_valid && rsp_hit && rsp_way == 1'b1, "R2 first", {rsp_valid, rsp_hit, rsp_way}, 3'b111);
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        chk(rsp_valid && rsp_hit && rsp_way == 1'b0, "R2 second", {rsp_valid, rsp_hit, rsp_way}, 3'b110);
        @(negedge clk);
        chk(!rsp_valid, "R2 idle", rsp_valid, 0);

        finish_run();
    end

endmodule